// File: doc/BRIEF.md
# Output-Compare Toggling PWM Generator

This block produces a pulse-width-modulated waveform from a free-running 16-bit tick counter and a single compare register. The output does not come from a comparison of a ramp against a duty threshold. It flips every time the counter reaches the compare value. After each flip, the compare register is moved forward to the next edge time. That time has already been computed and held in a one-edge-ahead cache. A phase flag inside the block records whether the coming edge is a rise or a fall. It therefore chooses whether the high interval or the low interval (period minus high) is added. The output pin is never consulted for this choice.

A host sets the high interval, in counts, through a byte-wide write port. Lower bytes only stage. Writing the top byte commits the whole word in one cycle, so an edge can never be scheduled from a half-written value. A committed value is saturated so that both the high and the low interval stay at least the latency margin. The adjustable span is therefore the period minus twice the margin. The period and the margin are elaboration parameters. For example, a 24.5 MHz tick with a 20 kHz output needs a period of 1225.

Top module: `pwm_oc_gen`

## Requirements
- R1: After reset the output is low, the tick counter is 0, and the committed high interval is HI_RESET (default PERIOD/2).
- R2: The tick counter advances by one every clock and wraps from 16'hFFFF to 0. All edge arithmetic is modulo 2^16, so interval lengths stay exact across a wrap.
- R3: While running (enable high in this cycle and the previous one), the output flips in the clock after the counter equals the compare value, and holds in every other clock.
- R4: Each high phase lasts exactly the high interval H in force for that period. The low phase that follows lasts PERIOD − H, so each period is exactly PERIOD clocks.
- R5: When enable is first sampled high, the output stays low, the phase flag selects a rising edge next, and the compare value becomes the counter value plus LATENCY. The first rise therefore occurs LATENCY clocks after that edge, whatever level the output had before it was disabled.
- R6: While enable is low the output is driven low from the next clock on.
- R7: A write with hw_sel = 0 only stages the low byte and changes nothing that is committed. A write with hw_sel = 1 commits {hw_byte, staged low byte} as the new high interval in that clock.
- R8: A committed value below LATENCY becomes LATENCY, a value above PERIOD − LATENCY becomes PERIOD − LATENCY, and values between the two are kept. The committed high interval always lies within these limits.
- R9: The committed high interval is sampled at each falling edge. That value sets the high and low intervals of the period that begins at the next rise. A commit made during a high phase does not change that high phase or the low phase after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low forces the output low and rearms the start sequence |
| hw_we | input | 1 | Host byte write strobe |
| hw_sel | input | 1 | Byte select: 0 stages the low byte, 1 writes the high byte and commits |
| hw_byte | input | 8 | Host write data byte |
| pwm_o | output | 1 | PWM output |

## Verification
The bench runs long enough to force the counter through its 16-bit wrap and checks every interval there. A design that compared the counter to the compare value as plain magnitudes, or that widened the additions, would stretch one interval by about 65536 clocks. It writes only the low byte while the high byte held different bits before. A design that committed on the low-byte write would then produce a visibly different duty. It also commits a new value in the middle of a high phase. A design that sampled the value at the rise, or that reused it for the low phase, would break the exact period. Finally it commits values just outside, exactly on, and far beyond both saturation limits, and it disables the block during a high phase. A missing clamp, an off-by-one limit, or a phase flag that survives disable would each show up as a wrong first interval or a wrong level.

// File: rtl/pwm_oc_pkg.sv
// Shared widths and types for the output-compare PWM generator.
// Assumes the tick width is a whole number of host bytes and at least two bytes.
package pwm_oc_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NB     = CNT_W / BYTE_W;
    localparam int SEL_W  = (NB > 1) ? $clog2(NB) : 1;

    typedef logic [CNT_W-1:0] tick_t;

    // Which edge the compare register is currently waiting for.
    typedef enum logic {
        PH_RISE_NEXT = 1'b0,
        PH_FALL_NEXT = 1'b1
    } phase_e;
endpackage

// File: rtl/pwm_oc_timebase.sv
// Free-running tick counter; wraps modulo 2^CNT_W.
// Assumes nothing about enable: it runs whenever reset is released.
module pwm_oc_timebase
    import pwm_oc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output tick_t cnt_o
);
    tick_t cnt_q;

    // Advance the tick count every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + tick_t'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_oc_hostreg.sv
// Byte-wide host write path for the high interval.
// Lower bytes are staged; writing the top byte commits the whole word,
// saturated to [LATENCY, PERIOD-LATENCY], in one clock.
// Assumes 2*LATENCY <= PERIOD < 2^CNT_W and HI_RESET inside the limits.
module pwm_oc_hostreg
    import pwm_oc_pkg::*;
#(
    parameter int PERIOD   = 1225,
    parameter int LATENCY  = 44,
    parameter int HI_RESET = PERIOD / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] din,
    output tick_t             hi_o
);
    localparam tick_t LO_LIM  = tick_t'(LATENCY);
    localparam tick_t HI_LIM  = tick_t'(PERIOD - LATENCY);
    localparam tick_t RST_VAL = tick_t'(HI_RESET);
    localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(NB - 1);

    logic [BYTE_W-1:0] stage_q [NB-1];
    tick_t             raw;
    tick_t             sat;
    tick_t             hi_q;
    logic              commit;

    // Capture writes aimed at the lower bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB - 1; i++) stage_q[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NB - 1; i++)
                if (sel == SEL_W'(i)) stage_q[i] <= din;
        end
    end

    // Assemble the candidate word from the staged bytes and the top byte.
    always_comb begin
        raw = '0;
        for (int i = 0; i < NB - 1; i++) raw[i*BYTE_W +: BYTE_W] = stage_q[i];
        raw[CNT_W-1 -: BYTE_W] = din;
    end

    // Saturate the candidate to the latency limits.
    always_comb begin
        if (raw < LO_LIM)      sat = LO_LIM;
        else if (raw > HI_LIM) sat = HI_LIM;
        else                   sat = raw;
    end

    assign commit = we && (sel == TOP_SEL);

    // Hold the committed high interval.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= RST_VAL;
        else if (commit) hi_q <= sat;
    end

    assign hi_o = hi_q;
endmodule

// File: rtl/pwm_oc_sched.sv
// Edge scheduler: compare register, one-edge-ahead cache, phase flag, output.
// On a compare match the output flips, the cached edge moves into the
// compare register, and the cache advances by the interval after that.
// The committed high interval is sampled at each fall. It fixes the period
// that starts at the following rise. All additions wrap modulo 2^CNT_W.
// Assumes every interval is at least 2 ticks (LATENCY >= 2).
module pwm_oc_sched
    import pwm_oc_pkg::*;
#(
    parameter int PERIOD  = 1225,
    parameter int LATENCY = 44
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  tick_t  cnt_i,
    input  tick_t  hi_i,
    output logic   pwm_o,
    output tick_t  cmp_o,
    output phase_e phase_o,
    output logic   run_o
);
    localparam tick_t PER_T = tick_t'(PERIOD);
    localparam tick_t LAT_T = tick_t'(LATENCY);

    logic   en_q;
    logic   start;
    logic   run;
    logic   hit;
    tick_t  cmp_q;
    tick_t  nxt_q;
    tick_t  hold_q;
    phase_e ph_q;
    logic   pwm_q;

    assign start = en && !en_q;
    assign run   = en && en_q;
    assign hit   = run && (cnt_i == cmp_q);

    // Remember the previous enable to find the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    // Place edges, flip the output and track which edge is next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= LAT_T;
            nxt_q  <= '0;
            hold_q <= '0;
            ph_q   <= PH_RISE_NEXT;
            pwm_q  <= 1'b0;
        end else if (!en) begin
            ph_q   <= PH_RISE_NEXT;
            pwm_q  <= 1'b0;
        end else if (start) begin
            cmp_q  <= cnt_i + LAT_T;
            nxt_q  <= cnt_i + LAT_T + hi_i;
            hold_q <= hi_i;
            ph_q   <= PH_RISE_NEXT;
            pwm_q  <= 1'b0;
        end else if (hit) begin
            pwm_q <= ~pwm_q;
            cmp_q <= nxt_q;
            if (ph_q == PH_RISE_NEXT) begin
                ph_q  <= PH_FALL_NEXT;
                nxt_q <= nxt_q + (PER_T - hold_q);
            end else begin
                ph_q   <= PH_RISE_NEXT;
                nxt_q  <= nxt_q + hi_i;
                hold_q <= hi_i;
            end
        end
    end

    assign pwm_o   = pwm_q;
    assign cmp_o   = cmp_q;
    assign phase_o = ph_q;
    assign run_o   = run;
endmodule

// File: rtl/pwm_oc_gen.sv
// Top level of the output-compare PWM generator.
// Wires the tick counter, the host write path and the edge scheduler.
// Assumes 2 <= LATENCY and 2*LATENCY <= PERIOD < 2^16.
module pwm_oc_gen
    import pwm_oc_pkg::*;
#(
    parameter int PERIOD   = 1225,
    parameter int LATENCY  = 44,
    parameter int HI_RESET = PERIOD / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hw_we,
    input  logic [SEL_W-1:0]  hw_sel,
    input  logic [BYTE_W-1:0] hw_byte,
    output logic              pwm_o
);
    tick_t  cnt_w;
    tick_t  hi_w;
    tick_t  cmp_w;
    phase_e phase_w;
    logic   run_w;

    pwm_oc_timebase u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt_w)
    );

    pwm_oc_hostreg #(
        .PERIOD   (PERIOD),
        .LATENCY  (LATENCY),
        .HI_RESET (HI_RESET)
    ) u_host (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hw_we),
        .sel   (hw_sel),
        .din   (hw_byte),
        .hi_o  (hi_w)
    );

    pwm_oc_sched #(
        .PERIOD  (PERIOD),
        .LATENCY (LATENCY)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .cnt_i   (cnt_w),
        .hi_i    (hi_w),
        .pwm_o   (pwm_o),
        .cmp_o   (cmp_w),
        .phase_o (phase_w),
        .run_o   (run_w)
    );
endmodule

// File: rtl/pwm_oc_chk.sv
// Property checker for pwm_oc_gen, attached by bind below.
module pwm_oc_chk
    import pwm_oc_pkg::*;
#(
    parameter int PERIOD  = 1225,
    parameter int LATENCY = 44
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             hw_we,
    input logic [SEL_W-1:0] hw_sel,
    input logic             pwm_o,
    input tick_t            cnt,
    input tick_t            cmp,
    input tick_t            hi_c,
    input phase_e           phase,
    input logic             run
);
    localparam tick_t LO_LIM = tick_t'(LATENCY);
    localparam tick_t HI_LIM = tick_t'(PERIOD - LATENCY);

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == $past(cnt) + tick_t'(1));

    p_flip_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == cmp) |=> pwm_o != $past(pwm_o));

    p_hold_off_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != cmp) |=> $stable(pwm_o));

    p_phase_matches_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FALL_NEXT) == pwm_o);

    p_start_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !run) |=> (!pwm_o && phase == PH_RISE_NEXT
                          && cmp == $past(cnt) + LO_LIM));

    p_low_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_o);

    p_stage_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && hw_sel == '0) |=> $stable(hi_c));

    p_hi_in_limits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_c >= LO_LIM && hi_c <= HI_LIM);
endmodule

bind pwm_oc_gen pwm_oc_chk #(
    .PERIOD  (PERIOD),
    .LATENCY (LATENCY)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .hw_we  (hw_we),
    .hw_sel (hw_sel),
    .pwm_o  (pwm_o),
    .cnt    (cnt_w),
    .cmp    (cmp_w),
    .hi_c   (hi_w),
    .phase  (phase_w),
    .run    (run_w)
);

// File: tb/pwm_oc_gen_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected (level, interval) edges and
// the monitor pops one for every output edge it sees.
module pwm_oc_gen_tb_top;
    localparam int P = 200;
    localparam int L = 10;

    typedef struct {
        logic  lvl;
        int    ivl;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       hw_we = 1'b0;
    logic [0:0] hw_sel = 1'b0;
    logic [7:0] hw_byte = 8'h00;
    logic       pwm_o;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   last = 0;
    logic prev = 1'b0;
    bit   armed = 1'b0;
    int   hcur = P / 2;

    pwm_oc_gen #(.PERIOD(P), .LATENCY(L)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .hw_we   (hw_we),
        .hw_sel  (hw_sel),
        .hw_byte (hw_byte),
        .pwm_o   (pwm_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc++;

    // Monitor: compare each observed edge against the queue head.
    always @(negedge clk) begin
        if (armed && pwm_o !== prev) begin
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected edge: actual level %0b after %0d, expected no edge",
                         pwm_o, cyc - last);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (pwm_o !== e.lvl || (cyc - last) != e.ivl) begin
                    n_bad++;
                    $display("FAIL %s: actual level %0b interval %0d, expected level %0b interval %0d",
                             e.req, pwm_o, cyc - last, e.lvl, e.ivl);
                end
            end
        end
        if (pwm_o !== prev) last = cyc;
        prev = pwm_o;
    end

    task automatic check(input string req, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0b, expected %0b", req, act, expv);
        end
    endtask

    task automatic push(input logic lvl, input int ivl, input string req);
        exp_t e;
        e.lvl = lvl; e.ivl = ivl; e.req = req;
        q.push_back(e);
    endtask

    function automatic int clampv(input int v);
        if (v < L) return L;
        if (v > P - L) return P - L;
        return v;
    endfunction

    task automatic wr(input logic s, input logic [7:0] b);
        @(negedge clk);
        hw_we = 1'b1; hw_sel = s; hw_byte = b;
        @(negedge clk);
        hw_we = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
    endtask

    // Called just after a rise is observed: queue the edges, then write.
    task automatic segment(input int raw, input int n, input bit full, input string req);
        int hn;
        hn = full ? clampv(raw) : hcur;
        push(1'b0, hcur, req);          // current high keeps old value (R9)
        push(1'b1, P - hcur, req);      // following low keeps old value (R9)
        for (int k = 0; k < n; k++) begin
            push(1'b0, hn, req);
            push(1'b1, P - hn, req);
        end
        wr(1'b0, raw[7:0]);
        if (full) wr(1'b1, raw[15:8]);
        hcur = hn;
        drain();
    endtask

    task automatic start_run(input string req);
        armed = 1'b1;
        @(negedge clk);
        en = 1'b1;
        last = cyc;
        push(1'b1, L + 1, req);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 output low in reset", pwm_o, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 output low after reset while disabled", pwm_o, 1'b0);

        // R5 first rise LATENCY after enable; R1 reset high interval P/2.
        start_run("R5");
        segment(64, 2, 1'b1, "R4");
        // R7: only the low byte written; committed value must stay 64.
        segment(32'h00FF, 2, 1'b0, "R7");
        segment(133, 2, 1'b1, "R9");
        segment(3, 1, 1'b1, "R8");
        segment(9, 1, 1'b1, "R8");
        segment(10, 1, 1'b1, "R8");
        segment(11, 1, 1'b1, "R8");
        segment(191, 1, 1'b1, "R8");
        segment(190, 1, 1'b1, "R8");
        segment(32'hFFFF, 1, 1'b1, "R8");
        segment(32'h0100, 1, 1'b1, "R8");
        // R2: run past a counter wrap.
        segment(77, 340, 1'b1, "R2");

        // R6: disable in a high phase.
        check("R6 high before disable", pwm_o, 1'b1);
        armed = 1'b0;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R6 low one clock after disable", pwm_o, 1'b0);
        repeat (2 * P) @(negedge clk);
        check("R6 stays low while disabled", pwm_o, 1'b0);

        // R5: restart from a fresh phase.
        start_run("R5 restart");
        segment(77, 2, 1'b1, "R4");

        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R4: actual %0d edges pending, expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R3 watchdog: actual hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule